// File: doc/BRIEF.md
# Real-Time Clock Interrupt Controller

This block holds the four control and status registers of a battery-backed real-time clock. It divides a 32.768 kHz tick strobe into a periodic interrupt, whose rate a 4-bit code selects, and into a once-per-second update request to the calendar counters. Ahead of each request it raises an update-in-progress flag, which software polls before it reads the time.

Software reaches the registers over a byte-wide bus with a 2-bit register select: 0 is control A (update flag, divisor, rate), 1 is control B (enables and set-time inhibit), 2 is the flag register and 3 is the valid-data register. Events latch into the flag register, which clears when it is read. The interrupt output is high while any latched flag has its enable set. The calendar counters acknowledge each update request with a done strobe. A power-fail strobe marks the battery-backed contents as suspect.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, control A reads 0x20 (divisor field 010, rate 0, update flag 0), control B reads 0x00, the flag register reads 0x00, the valid register reads 0x00 and `irq` is low.
- R2: Rate code c in control A bits 3:0 sets a periodic flag event once every P ticks. P is 2^(c-1) for c from 3 to 15, 128 for code 1 and 256 for code 2. Code 3 gives 4 ticks (122.07 µs) and code 15 gives 16384 ticks (500 ms).
- R3: Rate code 0 never produces a periodic flag event.
- R4: `irq` is high exactly while the flag register holds the periodic flag (bit 6) with periodic enable (control B bit 6) set, or the update flag (bit 4) with update enable (control B bit 4) set. Bit 7 of the flag register reads as that same condition.
- R5: Control A bit 7 (update in progress) rises LEAD_TICKS ticks before each `upd_req` pulse and stays high until `upd_done`. A `upd_done` that arrives while the flag is high sets the update flag (bit 4 of the flag register).
- R6: While control B bit 7 (set-time inhibit) is 1, the update-in-progress flag is forced to 0 and no `upd_req` is issued. Updates resume once the bit is cleared.
- R7: The flag register reads as {irq condition, periodic, alarm (always 0), update, 4'b0000}. A read clears all of its flags, so `irq` falls.
- R8: A flag event that lands in the same cycle as a read of the flag register is kept, and the next read reports it.
- R9: The valid register reads {VRT, 7'b0}. VRT becomes 1 after any read of that register, and a `pwr_fail` strobe clears it to 0.
- R10: When the divisor field (control A bits 6:4) holds any value other than 010, the tick counters are held at zero. No periodic events, no update flag and no `upd_req` occur in that state.
- R11: Writes to the flag register and to the valid register have no effect. A write to control A does not change bit 7.
- R12: Read data appears on `rdata` in the cycle after `rd_en`. It shows the register contents as they were before any clear or set caused by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select (0 A, 1 B, 2 flags, 3 valid) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| upd_done | input | 1 | Calendar counters finished an update |
| pwr_fail | input | 1 | Backup power lost strobe |
| upd_req | output | 1 | One-cycle request to advance the calendar |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that `upd_done` comes only in answer to an `upd_req` and never in the same cycle as that request. They also assume that `tick` is a single-cycle strobe and that a read and a write are never issued together. The stimulus keeps to these rules. The bench answers each request with one done pulse two cycles later, pulses `tick` on every other cycle, and issues each bus access as a separate strobe. The reference model in the bench follows the same input rules, so its update flag and flag events stay aligned with the design across set-time aborts and divisor changes.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

   typedef enum logic [1:0] {
      SEL_CTLA  = 2'd0,
      SEL_CTLB  = 2'd1,
      SEL_FLAGS = 2'd2,
      SEL_VALID = 2'd3
   } reg_sel_e;

   // divisor value that lets the time base run
   localparam logic [2:0] DIV_RUN = 3'b010;

   typedef struct packed {
      logic       inhibit;   // set-time: abort and block updates
      logic       per_en;    // periodic interrupt enable
      logic       alm_en;    // alarm enable (no alarm source here)
      logic       upd_en;    // update-ended interrupt enable
      logic [3:0] misc;      // stored, no function in this block
   } ctlb_t;

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
   parameter int TICKS_PER_SEC = 32768,
   parameter int LEAD_TICKS    = 8,
   parameter int RATE_W        = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       run_i,
   input  logic [3:0] rate_i,
   input  logic       inhibit_i,
   input  logic       upd_done_i,
   output logic       per_evt_o,
   output logic       upd_evt_o,
   output logic       uip_o,
   output logic       upd_req_o
);

   localparam int SEC_W = $clog2(TICKS_PER_SEC);
   localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(TICKS_PER_SEC - 1);
   localparam logic [SEC_W-1:0] SEC_WARN = SEC_W'(TICKS_PER_SEC - 1 - LEAD_TICKS);

   if (RATE_W < 14) begin : g_bad_rate_w
      $error("RATE_W must cover the slowest periodic rate (14 bits)");
   end
   if (LEAD_TICKS < 1 || TICKS_PER_SEC < LEAD_TICKS + 2) begin : g_bad_lead
      $error("LEAD_TICKS must be at least 1 and leave room in the second");
   end

   logic [RATE_W-1:0] pcnt_q;
   logic [SEC_W-1:0]  scnt_q;
   logic              uip_q;
   logic              req_q;
   logic [15:0]       tap;

   // one tap per rate code: all-ones in the low K bits ends a period
   assign tap[0] = 1'b0;
   for (genvar c = 1; c < 16; c++) begin : g_tap
      localparam int K = (c < 3) ? c + 6 : c - 1;
      assign tap[c] = &pcnt_q[K-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         scnt_q <= '0;
         uip_q  <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         req_q <= run_i & tick_i & (scnt_q == SEC_LAST) & uip_q & ~inhibit_i;
         if (!run_i) begin
            pcnt_q <= '0;
            scnt_q <= '0;
         end else if (tick_i) begin
            pcnt_q <= pcnt_q + 1'b1;
            scnt_q <= (scnt_q == SEC_LAST) ? '0 : scnt_q + 1'b1;
         end
         if (inhibit_i || !run_i)
            uip_q <= 1'b0;
         else if (tick_i && scnt_q == SEC_WARN)
            uip_q <= 1'b1;
         else if (upd_done_i)
            uip_q <= 1'b0;
      end
   end

   assign per_evt_o = run_i & tick_i & tap[rate_i];
   assign upd_evt_o = upd_done_i & uip_q & ~inhibit_i;
   assign uip_o     = uip_q;
   assign upd_req_o = req_q;

   a_r6_inhibit_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_i |=> !upd_req_o);
   a_r5_req_inside_uip: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req_o |-> uip_o);
   a_r10_halt_clears_uip: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !uip_o);
   a_r3_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_i == 4'd0) |-> !per_evt_o);

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags #(
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] evt_i,      // {periodic, alarm, update}
   input  logic [NFLAG-1:0] en_i,
   input  logic             clr_i,
   input  logic             vrd_i,
   input  logic             pwr_fail_i,
   output logic [NFLAG-1:0] flags_o,
   output logic             irq_o,
   output logic             vrt_o
);

   logic [NFLAG-1:0] flg_q;
   logic             vrt_q;

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flg_q[i] <= 1'b0;
         else        flg_q[i] <= (flg_q[i] & ~clr_i) | evt_i[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          vrt_q <= 1'b0;
      else if (pwr_fail_i) vrt_q <= 1'b0;
      else if (vrd_i)      vrt_q <= 1'b1;
   end

   assign flags_o = flg_q;
   assign irq_o   = |(flg_q & en_i);
   assign vrt_o   = vrt_q;

   a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[NFLAG-1] |=> flags_o[NFLAG-1]);
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && evt_i == '0) |=> flags_o == '0);
   a_r9_vrt_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (vrd_i && !pwr_fail_i) |=> vrt_o);
   a_r9_vrt_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail_i |=> !vrt_o);

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int         TICKS_PER_SEC = 32768,
   parameter int         LEAD_TICKS    = 8,
   parameter int         RATE_W        = 15,
   parameter logic [2:0] DIV_RESET     = DIV_RUN
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_en,
   input  logic       wr_en,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       tick,
   input  logic       upd_done,
   input  logic       pwr_fail,
   output logic       upd_req,
   output logic       irq
);

   logic [2:0] div_q;
   logic [3:0] rate_q;
   ctlb_t      ctlb_q;
   logic [7:0] rdata_q;
   logic [7:0] rd_mux;
   logic       run, uip, per_evt, upd_evt, irq_w, vrt;
   logic [2:0] flags;

   assign run = (div_q == DIV_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= DIV_RESET;
         rate_q <= '0;
         ctlb_q <= '0;
      end else if (wr_en) begin
         if (addr == SEL_CTLA) begin
            div_q  <= wdata[6:4];
            rate_q <= wdata[3:0];
         end
         if (addr == SEL_CTLB) ctlb_q <= ctlb_t'(wdata);
      end
   end

   rtc_timebase #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .LEAD_TICKS   (LEAD_TICKS),
      .RATE_W       (RATE_W)
   ) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .run_i     (run),
      .rate_i    (rate_q),
      .inhibit_i (ctlb_q.inhibit),
      .upd_done_i(upd_done),
      .per_evt_o (per_evt),
      .upd_evt_o (upd_evt),
      .uip_o     (uip),
      .upd_req_o (upd_req)
   );

   rtc_flags #(.NFLAG(3)) u_fl (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     ({per_evt, 1'b0, upd_evt}),
      .en_i      ({ctlb_q.per_en, ctlb_q.alm_en, ctlb_q.upd_en}),
      .clr_i     (rd_en && addr == SEL_FLAGS),
      .vrd_i     (rd_en && addr == SEL_VALID),
      .pwr_fail_i(pwr_fail),
      .flags_o   (flags),
      .irq_o     (irq_w),
      .vrt_o     (vrt)
   );

   always_comb begin
      unique case (addr)
         SEL_CTLA:  rd_mux = {uip, div_q, rate_q};
         SEL_CTLB:  rd_mux = ctlb_q;
         SEL_FLAGS: rd_mux = {irq_w, flags, 4'b0000};
         default:   rd_mux = {vrt, 7'b0};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_mux;
   end

   assign rdata = rdata_q;
   assign irq   = irq_w;

   a_r7_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == SEL_FLAGS) |=> rdata[3:0] == 4'b0000);
   a_r11_valid_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == SEL_VALID) |=> rdata[6:0] == 7'b0);

endmodule

// File: tb/sim_rtc_irq_ctrl.sv
module sim_rtc_irq_ctrl;
   localparam int TPS  = 64;
   localparam int LEAD = 8;

   logic       clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
   logic       tick = 0, upd_done = 0, pwr_fail = 0;
   logic [1:0] addr = 0;
   logic [7:0] wdata = 0;
   wire  [7:0] rdata;
   wire        upd_req, irq;

   always #4 clk = ~clk;   // 125 MHz

   rtc_irq_ctrl #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick(tick), .upd_done(upd_done),
      .pwr_fail(pwr_fail), .upd_req(upd_req), .irq(irq));

   int checks = 0, fails = 0;
   bit started = 0, tick_on = 0, finished = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int         m_pcnt, m_scnt, m_rd_addr;
   bit         m_uip, m_req, m_pf, m_uf, m_vrt, m_rd_v;
   logic [7:0] m_a, m_b, m_rd;

   function automatic int period(input logic [3:0] c);
      if (c == 0) return 0;
      if (c < 3)  return 64 << c;
      return 1 << (c - 1);
   endfunction

   function automatic bit m_irq();
      return (m_pf && m_b[6]) || (m_uf && m_b[4]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pcnt = 0; m_scnt = 0; m_uip = 0; m_req = 0; m_pf = 0; m_uf = 0;
         m_vrt = 0; m_rd_v = 0; m_a = 8'h20; m_b = 8'h00; m_rd = 0; m_rd_addr = 0;
      end else begin : mdl
         bit run, pfe, ufe, rdc;
         int p;
         run    = (m_a[6:4] == 3'b010);
         m_rd_v = rd_en;
         if (rd_en) begin
            m_rd_addr = addr;
            case (addr)
               2'd0:    m_rd = {m_uip, m_a[6:0]};
               2'd1:    m_rd = m_b;
               2'd2:    m_rd = {m_irq(), m_pf, 1'b0, m_uf, 4'h0};
               default: m_rd = {m_vrt, 7'h0};
            endcase
         end
         p     = period(m_a[3:0]);
         pfe   = run && tick && p != 0 && (m_pcnt % p == p - 1);
         ufe   = upd_done && m_uip && !m_b[7];
         m_req = run && tick && m_scnt == TPS - 1 && m_uip && !m_b[7];
         if (m_b[7] || !run)                       m_uip = 0;
         else if (tick && m_scnt == TPS - 1 - LEAD) m_uip = 1;
         else if (upd_done)                        m_uip = 0;
         if (!run) begin m_pcnt = 0; m_scnt = 0; end
         else if (tick) begin m_pcnt++; m_scnt = (m_scnt + 1) % TPS; end
         rdc  = rd_en && addr == 2'd2;
         m_pf = (m_pf && !rdc) || pfe;
         m_uf = (m_uf && !rdc) || ufe;
         if (pwr_fail) m_vrt = 0;
         else if (rd_en && addr == 2'd3) m_vrt = 1;
         if (wr_en && addr == 2'd0) m_a[6:0] = wdata[6:0];
         if (wr_en && addr == 2'd1) m_b = wdata;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && started && !finished) begin
         chk("R4 irq", irq, m_irq());
         chk("R5 upd_req", upd_req, m_req);
         if (m_rd_v) begin
            case (m_rd_addr)
               0:       chk("R5 R12 ctlA", rdata, m_rd);
               1:       chk("R12 ctlB", rdata, m_rd);
               2:       chk("R7 R12 flags", rdata, m_rd);
               default: chk("R9 R12 valid", rdata, m_rd);
            endcase
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   initial forever begin
      @(negedge clk);
      tick = tick_on ? ~tick : 1'b0;
   end

   initial forever begin
      @(negedge clk);
      if (upd_req) begin
         repeat (2) @(negedge clk);
         upd_done = 1;
         @(negedge clk);
         upd_done = 0;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk); rd_en = 1; addr = a;
      @(negedge clk); rd_en = 0; v = rdata;
   endtask

   // reads the flag register every cycle; counts reports over n reads
   task automatic burst_c(input int n, output int npf);
      npf = 0;
      @(negedge clk); rd_en = 1; addr = 2'd2;
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rdata[6]) npf++;
      end
      rd_en = 0;
   endtask

   task automatic count_req(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (upd_req) cnt++;
      end
   endtask

   task automatic wait_uip(output bit seen);
      logic [7:0] v;
      seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin
         rd(2'd0, v);
         if (v[7]) seen = 1;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finished = 1;
      summary();
      $finish;
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [7:0] v;
      int n, c;
      bit seen;
      repeat (5) @(negedge clk);
      rst_n = 1; started = 1;

      // R1 reset state
      chk("R1 irq", irq, 0);
      rd(2'd0, v); chk("R1 ctlA", v, 8'h20);
      rd(2'd1, v); chk("R1 ctlB", v, 8'h00);
      rd(2'd2, v); chk("R1 flags", v, 8'h00);
      rd(2'd3, v); chk("R1 valid", v, 8'h00);

      // R9 valid bit
      rd(2'd3, v); chk("R9 set by read", v, 8'h80);
      @(negedge clk); pwr_fail = 1; @(negedge clk); pwr_fail = 0;
      rd(2'd3, v); chk("R9 cleared by power loss", v, 8'h00);
      rd(2'd3, v); chk("R9 set again", v, 8'h80);

      // R11 read-only writes
      wr(2'd2, 8'hFF); rd(2'd2, v); chk("R11 flags write ignored", v, 8'h00);
      wr(2'd3, 8'h00); rd(2'd3, v); chk("R11 valid write ignored", v, 8'h80);
      wr(2'd0, 8'hA5); rd(2'd0, v); chk("R11 ctlA bit7 read-only", v, 8'h25);
      wr(2'd0, 8'h20);

      // R2 rates, R8 events kept under back-to-back reads
      tick_on = 1;
      wr(2'd0, 8'h23); burst_c(80, n);    chk("R2 R8 code3 events", n, 10);
      wr(2'd0, 8'h24); burst_c(80, n);    chk("R2 code4 events", n, 5);
      wr(2'd0, 8'h21); burst_c(512, n);   chk("R2 code1 events", n, 2);
      wr(2'd0, 8'h22); burst_c(512, n);   chk("R2 code2 events", n, 1);
      wr(2'd0, 8'h2F); burst_c(32768, n); chk("R2 code15 events", n, 1);
      wr(2'd0, 8'h20); burst_c(200, n);   chk("R3 code0 silent", n, 0);

      // R4 enable gating
      wr(2'd0, 8'h23); wr(2'd1, 8'h00);
      repeat (20) @(negedge clk);
      chk("R4 irq masked", irq, 0);
      rd(2'd2, v); chk("R4 pf without irqf", {v[7], v[6]}, 2'b01);
      wr(2'd1, 8'h40);
      repeat (10) @(negedge clk);
      chk("R4 irq with enable", irq, 1);
      wr(2'd0, 8'h20);
      rd(2'd2, v); chk("R4 irqf in flags", v[7], 1);
      chk("R7 irq drops after read", irq, 0);

      // R5 update-in-progress and update flag
      wr(2'd1, 8'h00); rd(2'd2, v);
      wait_uip(seen); chk("R5 uip rises", seen, 1);
      count_req(40, c); chk("R5 request after uip", c, 1);
      repeat (6) @(negedge clk);
      rd(2'd0, v); chk("R5 uip ends at done", v[7], 0);
      rd(2'd2, v); chk("R7 flags format uf only", v, 8'h10);
      wr(2'd1, 8'h10);
      seen = 0;
      for (int i = 0; i < 300 && !seen; i++) begin
         @(negedge clk);
         if (irq) seen = 1;
      end
      chk("R5 update irq", seen, 1);
      rd(2'd2, v); chk("R7 flags format uf+irqf", v, 8'h90);
      chk("R7 irq cleared", irq, 0);

      // R6 set-time inhibit
      wr(2'd1, 8'h00);
      wait_uip(seen); chk("R6 uip before abort", seen, 1);
      wr(2'd1, 8'h80);
      rd(2'd0, v); chk("R6 abort clears uip", v[7], 0);
      count_req(400, c); chk("R6 no requests while set", c, 0);
      wr(2'd1, 8'h00);
      count_req(300, c); chk("R6 updates resume", c > 0, 1);

      // R10 divisor halts the time base
      wr(2'd0, 8'h03); rd(2'd2, v);
      count_req(400, c); chk("R10 no requests", c, 0);
      rd(2'd2, v); chk("R10 no flags", v, 8'h00);
      rd(2'd0, v); chk("R10 ctlA readback", v, 8'h03);
      wr(2'd0, 8'h20);
      repeat (4) @(negedge clk);

      finished = 1;
      summary();
      $finish;
   end

endmodule